// File: doc/BRIEF.md
# Operand Shift Unit with Rotate-Extend

This block reshapes a register operand on its way into an arithmetic unit. It is purely combinational. It takes the operand, a two-bit shift kind, a shift distance and the current carry flag. It returns the reshaped value and a shifter carry. A flag-setting instruction may capture that carry in the flag register. Capturing it is the caller's decision and lies outside this block.

Four kinds are selected by code: logical left, logical right, arithmetic right and rotate right. A separate select input requests a rotate-extend. A rotate-extend is a one-place right rotation through the carry flag. It overrides the kind code and the distance. Every kind yields a carry. A zero distance leaves the operand and the carry flag untouched.

Top module: `operand_shifter`

## Requirements
- R1: Kind code 0 is a logical left shift. Vacated low bits are zero, so a distance of 3 multiplies the operand by 8 (modulo 2^32).
- R2: Kind code 1 is a logical right shift. Vacated high bits are zero.
- R3: Kind code 2 is an arithmetic right shift. Vacated high bits are copies of operand bit 31.
- R4: Kind code 3 is a rotate right. Bits leaving bit 0 re-enter at bit 31, so no bit is lost.
- R5: When the extend select is 1, the result is {carry_in, operand[31:1]} and the carry out is operand[0]. The kind code and the distance have no effect in this case.
- R6: With the extend select at 0 and a distance of 0, the result equals the operand and the carry out equals carry_in, for every kind code.
- R7: For a left shift by n in 1..31, the carry out is operand[32-n], the last bit pushed past the top.
- R8: For a right shift or a rotate by n in 1..31, the carry out is operand[n-1], the last bit pushed past bit 0.
- R9: Outside rotate-extend, carry_in has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Operand to be shifted |
| kind_i | input | 2 | Shift kind: 0 left logical, 1 right logical, 2 right arithmetic, 3 rotate right |
| amt_i | input | 5 | Shift distance, 0 to 31 |
| rrx_i | input | 1 | Selects the one-place rotate through carry |
| cin_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted operand |
| cout_o | output | 1 | Shifter carry out |

## Verification
Two functions can act on the same input set. The rotate-extend select can be raised while the kind code and the distance still request an ordinary shift. A zero distance can also coincide with any kind code, in which case the carry must pass straight through. The bench provokes both situations with directed vectors, and with pseudo-random vectors in which the extend select and a zero distance appear often. A behavioural model computes the expected result and carry with native shift operators. A wrong priority between the two paths shows up as a mismatch in either the result or the carry.

// File: rtl/opshift_pkg.sv
package opshift_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'd0,
    SK_LSR = 2'd1,
    SK_ASR = 2'd2,
    SK_ROR = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/opshift_rev.sv
module opshift_rev #(
  parameter int W = 32
) (
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign q_o[i] = d_i[W-1-i];
  end
endmodule

// File: rtl/opshift_barrel.sv
// Right-going logarithmic shifter; each stage moves by a power of two.
module opshift_barrel #(
  parameter int W     = 32,
  parameter int AMT_W = $clog2(W)
) (
  input  logic [W-1:0]     d_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             fill_i,
  input  logic             rot_i,
  output logic [W-1:0]     q_o
);
  logic [W-1:0] stg [0:AMT_W];
  assign stg[0] = d_i;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [W-1:0] moved;
    always_comb begin
      if (rot_i) moved = {stg[k][S-1:0], stg[k][W-1:S]};
      else       moved = {{S{fill_i}}, stg[k][W-1:S]};
    end
    assign stg[k+1] = amt_i[k] ? moved : stg[k];
  end

  assign q_o = stg[AMT_W];
endmodule

// File: rtl/opshift_carry.sv
// Picks the last bit pushed past bit 0 of the right-aligned source.
module opshift_carry #(
  parameter int W     = 32,
  parameter int AMT_W = $clog2(W)
) (
  input  logic [W-1:0]     src_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             cin_i,
  output logic             cout_o
);
  localparam logic [AMT_W-1:0] ONE = 1;
  logic [AMT_W-1:0] idx;
  assign idx = amt_i - ONE;
  always_comb begin
    if (amt_i == '0) cout_o = cin_i;
    else             cout_o = src_i[idx];
  end
endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
  import opshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [1:0]        kind_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              rrx_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] result_o,
  output logic              cout_o
);
  shift_kind_e       kind;
  logic              is_left, fill, rot;
  logic [DATA_W-1:0] opnd_rev, pre, bar_out, bar_rev, shifted;
  logic              sh_carry;

  assign kind    = shift_kind_e'(kind_i);
  assign is_left = (kind == SK_LSL);
  assign rot     = (kind == SK_ROR);
  assign fill    = (kind == SK_ASR) ? opnd_i[DATA_W-1] : 1'b0;

  // Left shifts run through the right shifter on a mirrored operand.
  opshift_rev #(.W(DATA_W)) u_rev_in  (.d_i(opnd_i),  .q_o(opnd_rev));
  assign pre = is_left ? opnd_rev : opnd_i;

  opshift_barrel #(.W(DATA_W), .AMT_W(AMT_W)) u_barrel (
    .d_i(pre), .amt_i(amt_i), .fill_i(fill), .rot_i(rot), .q_o(bar_out)
  );

  opshift_rev #(.W(DATA_W)) u_rev_out (.d_i(bar_out), .q_o(bar_rev));
  assign shifted = is_left ? bar_rev : bar_out;

  opshift_carry #(.W(DATA_W), .AMT_W(AMT_W)) u_carry (
    .src_i(pre), .amt_i(amt_i), .cin_i(cin_i), .cout_o(sh_carry)
  );

  // Rotate-extend takes priority over kind and distance.
  always_comb begin
    if (rrx_i) begin
      result_o = {cin_i, opnd_i[DATA_W-1:1]};
      cout_o   = opnd_i[0];
    end else begin
      result_o = shifted;
      cout_o   = sh_carry;
    end
  end

  always_comb begin
    if (!rrx_i && amt_i == '0) begin
      AST_ZERO_PASS: assert (result_o == opnd_i && cout_o == cin_i) else $error("zero distance altered data"); // R6
    end
    if (rrx_i) begin
      AST_RRX_TOP: assert (result_o[DATA_W-1] == cin_i) else $error("extend top bit wrong"); // R5
    end
    if (!rrx_i && kind == SK_ROR) begin
      AST_ROR_KEEP: assert ($countones(result_o) == $countones(opnd_i)) else $error("rotate lost bits"); // R4
    end
    if (!rrx_i && kind == SK_LSR && amt_i != '0) begin
      AST_LSR_TOP_ZERO: assert (result_o[DATA_W-1] == 1'b0) else $error("right logical fill"); // R2
    end
    if (!rrx_i && kind == SK_ASR) begin
      AST_ASR_SIGN: assert (result_o[DATA_W-1] == opnd_i[DATA_W-1]) else $error("sign not kept"); // R3
    end
    if (!rrx_i && kind == SK_LSL && amt_i != '0) begin
      AST_LSL_LOW_ZERO: assert (result_o[0] == 1'b0) else $error("left fill"); // R1
    end
  end
endmodule

// File: tb/operand_shifter_test.sv
module operand_shifter_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk, rst_n;
  logic [31:0] opnd;
  logic [1:0]  kind;
  logic [4:0]  amt;
  logic        rrx, cin;
  logic [31:0] result;
  logic        cout;

  int checks, failures, cycles;
  bit done;
  logic [31:0] lcg;

  operand_shifter uut (
    .opnd_i(opnd), .kind_i(kind), .amt_i(amt), .rrx_i(rrx), .cin_i(cin),
    .result_o(result), .cout_o(cout)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [32:0] model(logic [31:0] a, int k, int n, bit x, bit c);
    logic [31:0] r;
    logic co;
    if (x) return {a[0], c, a[31:1]};
    if (n == 0) return {c, a};
    case (k)
      0: begin r = a << n; co = a[32-n]; end
      1: begin r = a >> n; co = a[n-1]; end
      2: begin r = 32'($signed(a) >>> n); co = a[n-1]; end
      default: begin r = (a >> n) | (a << (32-n)); co = a[n-1]; end
    endcase
    return {co, r};
  endfunction

  function automatic string tag_of(int k, int n, bit x);
    if (x) return "R5";
    if (n == 0) return "R6";
    case (k)
      0: return "R1 R7 R9";
      1: return "R2 R8 R9";
      2: return "R3 R8 R9";
      default: return "R4 R8 R9";
    endcase
  endfunction

  task automatic apply(logic [31:0] a, int k, int n, bit x, bit c);
    logic [32:0] exp;
    @(posedge clk);
    #1;
    opnd = a; kind = 2'(k); amt = 5'(n); rrx = x; cin = c;
    @(negedge clk);
    exp = model(a, k, n, x, c);
    checks++;
    if ({cout, result} !== exp) begin
      failures++;
      $display("FAIL %s a=%h k=%0d n=%0d x=%0b c=%0b actual=%b_%h expected=%b_%h",
               tag_of(k, n, x), a, k, n, x, c, cout, result, exp[32], exp[31:0]);
    end
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG && !done) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    checks = 0; failures = 0; done = 0;
    opnd = '0; kind = '0; amt = '0; rrx = 0; cin = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;  // reset state with idle inputs (R6)
    if (result !== 32'h0 || cout !== 1'b0) begin
      failures++;
      $display("FAIL R6 reset actual=%b_%h expected=0_00000000", cout, result);
    end
    // R1: multiply by 8
    apply(32'h0000_0005, 0, 3, 0, 0);
    apply(32'h8000_0001, 0, 1, 0, 0);   // R7 carry from top bit
    apply(32'h4000_0000, 0, 31, 0, 1);  // R7 far end, cin ignored (R9)
    apply(32'hF000_000F, 1, 4, 0, 1);   // R2 with R8
    apply(32'h8000_0000, 1, 31, 0, 0);  // R2 max distance
    apply(32'h8000_0010, 2, 4, 0, 0);   // R3 negative
    apply(32'h7000_0010, 2, 5, 0, 1);   // R3 positive
    apply(32'h8000_0000, 2, 31, 0, 0);  // R3 all ones
    apply(32'h0000_0001, 3, 1, 0, 0);   // R4 wrap
    apply(32'h1234_5678, 3, 16, 0, 1);  // R4 halves
    apply(32'hDEAD_BEEF, 0, 0, 0, 1);   // R6 every kind
    apply(32'hDEAD_BEEF, 1, 0, 0, 0);
    apply(32'hDEAD_BEEF, 2, 0, 0, 1);
    apply(32'hDEAD_BEEF, 3, 0, 0, 0);
    apply(32'h0000_0003, 0, 7, 1, 1);   // R5 overrides left shift
    apply(32'h8000_0002, 2, 0, 1, 0);   // R5 with zero distance
    apply(32'hFFFF_FFFE, 3, 12, 1, 1);  // R5 overrides rotate
    lcg = 32'h1ACE_5EED;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      a = lcg ^ {lcg[15:0], lcg[31:16]};
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      apply(a, int'(lcg[29:28]), (lcg[27:25] == 3'd0) ? 0 : int'(lcg[24:20]),
            lcg[19:17] == 3'd0, lcg[12]);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule